// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the two threshold offsets that a FIFO's flag logic compares against its fill level: one for the almost-empty flag and one for the almost-full flag. It drives both offsets continuously to the flag logic. Software or a controller can set or inspect them through three paths, all on one clock. The first is a bit-serial load, one bit per enabled cycle. The second is a parallel load of a whole offset word per cycle. The third is a parallel read-back that places an offset on the output bus.

Every path visits the registers in a fixed order: the empty offset first, then the full offset, then the empty offset again. A single shared pointer tracks which register is next. Dropping the load strobe sends the pointer back to the empty offset and clears the serial bit count. Read-back needs one idle cycle between accesses. A read request in the cycle right after another read request is dropped and sets a sticky error bit.

Top module: `flag_offset_prog`

## Requirements
- R1: While rst_ni is low, and from then until the first access, both offsets equal DEF_OFF (default 127), q_o is 0, and q_vld_o and rd_err_o are 0.
- R2: With ld_i and wen_i high at a clock edge, d_i is written to the register the pointer selects, and the pointer advances. After the strobe rises, the first such write goes to empty_off_o and the second to full_off_o. The new value is visible after that edge.
- R3: With ld_i and sen_i high and wen_i and ren_i low, si_i is shifted into the selected register, least significant bit first. After exactly OFF_W shifts the register holds the serial word and the pointer moves to the other register.
- R4: An accepted read (ld_i and ren_i high, wen_i low) loads the selected offset into q_o and raises q_vld_o for one cycle after that edge. The first read after the strobe rises returns the empty offset and the next returns the full offset.
- R5: A read request in the cycle directly after a read request is ignored: q_vld_o stays low, q_o keeps its value and the pointer does not move. So q_vld_o is never high in two consecutive cycles.
- R6: An ignored read request sets rd_err_o after that edge. rd_err_o then stays high until reset.
- R7: A cycle with ld_i low returns the pointer to the empty offset and clears the serial bit count. Bits already shifted in stay in the register.
- R8: In one cycle a write takes precedence over a read, and a read takes precedence over a shift. With ld_i low, wen_i, ren_i and sen_i have no effect on the offsets or on q_o.
- R9: After an access to the full offset the pointer wraps, so the third access after the strobe rises targets the empty offset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all paths |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load strobe, active high, qualifies every access |
| wen_i | input | 1 | Parallel write enable |
| ren_i | input | 1 | Parallel read enable |
| sen_i | input | 1 | Serial shift enable |
| si_i | input | 1 | Serial data bit |
| d_i | input | OFF_W | Parallel write data |
| q_o | output | OFF_W | Read-back data |
| q_vld_o | output | 1 | One-cycle pulse when q_o has been loaded |
| empty_off_o | output | OFF_W | Current almost-empty offset |
| full_off_o | output | OFF_W | Current almost-full offset |
| rd_err_o | output | 1 | Sticky error: a read was attempted without the idle cycle |

## Verification
The hardest state to reach from the ports is a partial serial load cut off by the strobe. If the bit counter were not cleared, a later serial word would cross into the full offset part-way through. The stimulus shifts five bits, drops ld_i for one cycle, then shifts a complete word and checks that all of it lands in the empty offset while the full offset keeps its value. A second state is a rejected read sitting between two accepted ones. The bench holds ren_i high for two cycles, then idles one cycle and reads again, and checks that the pointer did not move on the rejected cycle.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} off_sel_e;
endpackage

// File: rtl/foff_ptr.sv
module foff_ptr
  import flag_offset_pkg::*;
#(
  parameter int OFF_W = 14
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ld_i,
  input  logic      wr_i,
  input  logic      rd_i,
  input  logic      sh_i,
  output off_sel_e  sel_o,
  output logic      sh_last_o
);
  localparam int CNT_W = (OFF_W > 1) ? $clog2(OFF_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OFF_W - 1);

  logic [CNT_W-1:0] bit_cnt_q;
  off_sel_e         sel_q;

  assign sh_last_o = sh_i && (bit_cnt_q == LAST);
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SEL_EMPTY;
      bit_cnt_q <= '0;
    end else if (!ld_i) begin
      sel_q     <= SEL_EMPTY;
      bit_cnt_q <= '0;
    end else begin
      if (wr_i || rd_i)   bit_cnt_q <= '0;
      else if (sh_last_o) bit_cnt_q <= '0;
      else if (sh_i)      bit_cnt_q <= bit_cnt_q + 1'b1;
      if (wr_i || rd_i || sh_last_o)
        sel_q <= (sel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end
endmodule

// File: rtl/foff_rd_guard.sv
module foff_rd_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  output logic rd_ok_o,
  output logic err_o
);
  logic prev_req_q;
  logic err_q;

  assign rd_ok_o = rd_req_i && !prev_req_q;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_req_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      prev_req_q <= rd_req_i;
      if (rd_req_i && prev_req_q) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/foff_bank.sv
module foff_bank
  import flag_offset_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int DEF_OFF = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  off_sel_e         sel_i,
  input  logic             wr_i,
  input  logic             sh_i,
  input  logic             si_i,
  input  logic [OFF_W-1:0] d_i,
  output logic [OFF_W-1:0] empty_o,
  output logic [OFF_W-1:0] full_o,
  output logic [OFF_W-1:0] rd_data_o
);
  localparam logic [OFF_W-1:0] RST_VAL = OFF_W'(DEF_OFF);

  logic [1:0][OFF_W-1:0] vals;

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam off_sel_e MY_SEL = (g == 0) ? SEL_EMPTY : SEL_FULL;
    logic [OFF_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= RST_VAL;
      else if (sel_i == MY_SEL) begin
        if (wr_i)      val_q <= d_i;
        else if (sh_i) val_q <= {si_i, val_q[OFF_W-1:1]};  // LSB arrives first
      end
    end
    assign vals[g] = val_q;
  end

  assign empty_o   = vals[0];
  assign full_o    = vals[1];
  assign rd_data_o = (sel_i == SEL_FULL) ? vals[1] : vals[0];
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import flag_offset_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int DEF_OFF = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             wen_i,
  input  logic             ren_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic [OFF_W-1:0] d_i,
  output logic [OFF_W-1:0] q_o,
  output logic             q_vld_o,
  output logic [OFF_W-1:0] empty_off_o,
  output logic [OFF_W-1:0] full_off_o,
  output logic             rd_err_o
);
  logic             wr_acc, rd_req, rd_ok, sh_acc, sh_last;
  off_sel_e         sel;
  logic [OFF_W-1:0] rd_data;
  logic [OFF_W-1:0] q_q;
  logic             vld_q;

  // priority: write, then read, then shift
  assign wr_acc = ld_i && wen_i;
  assign rd_req = ld_i && !wen_i && ren_i;
  assign sh_acc = ld_i && !wen_i && !ren_i && sen_i;

  foff_rd_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req),
    .rd_ok_o  (rd_ok),
    .err_o    (rd_err_o)
  );

  foff_ptr #(.OFF_W(OFF_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_i),
    .wr_i      (wr_acc),
    .rd_i      (rd_ok),
    .sh_i      (sh_acc),
    .sel_o     (sel),
    .sh_last_o (sh_last)
  );

  foff_bank #(.OFF_W(OFF_W), .DEF_OFF(DEF_OFF)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .wr_i      (wr_acc),
    .sh_i      (sh_acc),
    .si_i      (si_i),
    .d_i       (d_i),
    .empty_o   (empty_off_o),
    .full_o    (full_off_o),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_ok;
      if (rd_ok) q_q <= rd_data;
    end
  end

  assign q_o     = q_q;
  assign q_vld_o = vld_q;
endmodule

// File: rtl/flag_offset_prog_chk.sv
module flag_offset_prog_chk #(
  parameter int OFF_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_i,
  input logic             wen_i,
  input logic             ren_i,
  input logic [OFF_W-1:0] q_o,
  input logic             q_vld_o,
  input logic [OFF_W-1:0] empty_off_o,
  input logic [OFF_W-1:0] full_off_o,
  input logic             rd_err_o
);
  a_r4_vld_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_vld_o |-> $past(ld_i && ren_i && !wen_i));

  a_r4_q_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_vld_o |-> $stable(q_o));

  a_r5_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_vld_o |=> !q_vld_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> rd_err_o);

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_err_o) |-> ($past(ld_i && ren_i && !wen_i) && $past(ld_i && ren_i && !wen_i, 2)));

  a_r8_idle_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> ($stable(empty_off_o) && $stable(full_off_o) && !q_vld_o));

  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(empty_off_o) && !$stable(full_off_o)));
endmodule

bind flag_offset_prog flag_offset_prog_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_i        (ld_i),
  .wen_i       (wen_i),
  .ren_i       (ren_i),
  .q_o         (q_o),
  .q_vld_o     (q_vld_o),
  .empty_off_o (empty_off_o),
  .full_off_o  (full_off_o),
  .rd_err_o    (rd_err_o)
);

// File: tb/sim_flag_offset_prog.sv
module sim_flag_offset_prog;
  localparam int CLK_P = 10;
  localparam int W     = 14;
  localparam int NV    = 14;

  typedef struct packed {
    logic         ld;
    logic         wen;
    logic         ren;
    logic         sen;
    logic [W-1:0] d;
    logic [W-1:0] ee;
    logic [W-1:0] ef;
    logic [W-1:0] eq;
    logic         ev;
    logic         eerr;
    logic [3:0]   req;
  } vec_t;

  // expectations are sampled just after the edge that applies the row
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,14'h0123,14'h0123,14'd127 ,14'h0000,1'b0,1'b0,4'd2}, // R2 first write -> empty
    '{1'b1,1'b1,1'b0,1'b0,14'h2abc,14'h0123,14'h2abc,14'h0000,1'b0,1'b0,4'd2}, // R2 second write -> full
    '{1'b1,1'b1,1'b0,1'b0,14'h0055,14'h0055,14'h2abc,14'h0000,1'b0,1'b0,4'd9}, // R9 wrap to empty
    '{1'b0,1'b0,1'b0,1'b0,14'h0000,14'h0055,14'h2abc,14'h0000,1'b0,1'b0,4'd7}, // R7 strobe low
    '{1'b1,1'b0,1'b1,1'b0,14'h0000,14'h0055,14'h2abc,14'h0055,1'b1,1'b0,4'd4}, // R4 read empty
    '{1'b1,1'b0,1'b0,1'b0,14'h0000,14'h0055,14'h2abc,14'h0055,1'b0,1'b0,4'd4}, // R4 idle gap
    '{1'b1,1'b0,1'b1,1'b0,14'h0000,14'h0055,14'h2abc,14'h2abc,1'b1,1'b0,4'd4}, // R4 read full
    '{1'b1,1'b0,1'b1,1'b0,14'h0000,14'h0055,14'h2abc,14'h2abc,1'b0,1'b1,4'd5}, // R5 R6 rejected
    '{1'b1,1'b0,1'b0,1'b0,14'h0000,14'h0055,14'h2abc,14'h2abc,1'b0,1'b1,4'd6}, // R6 sticky
    '{1'b1,1'b0,1'b1,1'b0,14'h0000,14'h0055,14'h2abc,14'h0055,1'b1,1'b1,4'd5}, // R5 pointer held
    '{1'b0,1'b0,1'b0,1'b0,14'h0000,14'h0055,14'h2abc,14'h0055,1'b0,1'b1,4'd7}, // R7
    '{1'b1,1'b1,1'b1,1'b0,14'h0777,14'h0777,14'h2abc,14'h0055,1'b0,1'b1,4'd8}, // R8 write beats read
    '{1'b0,1'b1,1'b0,1'b0,14'h1111,14'h0777,14'h2abc,14'h0055,1'b0,1'b1,4'd8}, // R8 write w/o strobe
    '{1'b0,1'b0,1'b1,1'b0,14'h0000,14'h0777,14'h2abc,14'h0055,1'b0,1'b1,4'd8}  // R8 read w/o strobe
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld = 1'b0, wen = 1'b0, ren = 1'b0, sen = 1'b0, si = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q, eo, fo;
  logic         qv, err;
  int           n_chk = 0;
  int           n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  flag_offset_prog #(.OFF_W(W), .DEF_OFF(127)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .ld_i (ld), .wen_i (wen), .ren_i (ren),
    .sen_i (sen), .si_i (si), .d_i (d), .q_o (q), .q_vld_o (qv),
    .empty_off_o (eo), .full_off_o (fo), .rd_err_o (err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic l, input logic w, input logic r, input logic s,
                       input logic b, input logic [W-1:0] dv);
    ld = l; wen = w; ren = r; sen = s; si = b; d = dv;
  endtask

  task automatic shift_word(input logic [W-1:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, v[i], '0);
      step();
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2);
    // R1 values during reset
    chk("R1", "empty", 32'(eo), 32'd127);
    chk("R1", "full", 32'(fo), 32'd127);
    chk("R1", "q", 32'(q), 32'd0);
    chk("R1", "vld/err", {30'd0, qv, err}, 32'd0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      drive(TBL[i].ld, TBL[i].wen, TBL[i].ren, TBL[i].sen, 1'b0, TBL[i].d);
      step();
      chk(tag, "empty", 32'(eo), 32'(TBL[i].ee));
      chk(tag, "full", 32'(fo), 32'(TBL[i].ef));
      chk(tag, "q", 32'(q), 32'(TBL[i].eq));
      chk(tag, "vld", 32'(qv), 32'(TBL[i].ev));
      chk(tag, "err", 32'(err), 32'(TBL[i].eerr));
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step();

    // R3 serial: empty word then full word, LSB first
    shift_word(14'h1a5c, W);
    chk("R3", "serial empty", 32'(eo), 32'h1a5c);
    chk("R3", "full untouched", 32'(fo), 32'h2abc);
    ld = 1'b1;
    shift_word(14'h0f0f, 0);
    // continue the same strobe: second word goes to full
    for (int i = 0; i < W; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, (14'h0f0f >> i) & 14'h1, '0);
      step();
    end
    chk("R3", "serial full", 32'(fo), 32'h0f0f);
    chk("R3", "empty kept", 32'(eo), 32'h1a5c);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step();

    // R7 partial serial then strobe drop: bit count must restart
    shift_word(14'h3fff, 5);
    step();
    shift_word(14'h0333, W);
    chk("R7", "empty after restart", 32'(eo), 32'h0333);
    chk("R7", "full kept", 32'(fo), 32'h0f0f);
    step();

    // R8 read beats shift; R4 first read after strobe returns empty
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    step();
    chk("R8", "read wins q", 32'(q), 32'h0333);
    chk("R8", "read wins vld", 32'(qv), 32'd1);
    chk("R8", "no shift", 32'(eo), 32'h0333);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step();

    // R1 reset during activity
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0abc);
    rst_n = 1'b0;
    #2;
    chk("R1", "empty in reset", 32'(eo), 32'd127);
    chk("R1", "full in reset", 32'(fo), 32'd127);
    chk("R1", "q/vld/err in reset", {17'd0, q, qv, err}, 32'd0);
    step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    step();
    chk("R1", "empty after reset", 32'(eo), 32'd127);
    chk("R6", "err cleared only by reset", 32'(err), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule